// File: doc/BRIEF.md
# Low-Power Entry and Exit Sequencer

This block walks a processor subsystem down into a nap or sleep state and back up again. When the core pulls its active-low quiesce request low, and software has permitted power-down for the target state, the sequencer stops the system bus arbiter first. It then stops the memory controller and the bus-bridge gasket together, halts the memory clock once the memory controller agrees, and turns on the isolation cells between the regions that stay powered and the regions that may lose supply. Only after that does it acknowledge the core, raise the external quiesce output and, if software asked for it, drop the external power-control line.

A wake pulse runs the same steps in reverse. Power is restored, a programmable settle count runs down, isolation is released, the memory clock restarts, the memory and gasket stops are withdrawn, then the arbiter stop, and finally the core acknowledge is released. A small register slice holds the target state, the committed current state, the two permission bits, the power-off bit and a pending power-management event flag. That flag may be cleared only when the committed state matches the target.

Top module: `lp_quiesce_seq`

## Requirements
- R1: With power-down permitted, a low on `core_qreq_n` raises `arb_stop_req` on the next cycle. `mc_stop_req` and `gk_stop_req` stay low until `arb_stop_ack` has been seen high.
- R2: In the cycle after `arb_stop_ack` is seen, `mc_stop_req` and `gk_stop_req` rise together. While they are high, `arb_stop_req` stays high.
- R3: `mem_clk_stop` rises in the cycle after `mc_stop_ack` is seen while the memory stops are pending. It stays high until the wake sequence restarts the clock.
- R4: `iso_en` rises in the cycle after `mc_stop_ack` and `gk_stop_ack` are both high. One cycle later `core_qack_n` goes low and `ext_quiesce` goes high.
- R5: In the sleep state, `ext_pwr_ctrl` is low when the power-off bit is set and high when it is clear. It is low only while isolation is on and the core is acknowledged.
- R6: A pulse on `sw_commit` copies the next-state field into `cur_state`. `evt_set` sets `evt_pending`. `evt_clr` clears it only when the current state equals the next state, and is ignored otherwise.
- R7: State codes are 00 run, 01 nap, 10 sleep and 11 run. A quiesce request starts the sequence only for next-state 10 with the sleep enable set, or for next-state 01 with the nap enable set. Otherwise all stop requests stay low and `core_qack_n` stays high.
- R8: A `wake` pulse in sleep raises `ext_pwr_ctrl` on the next cycle. `iso_en` stays high for exactly `settle_cnt`+1 cycles after that, then falls. `mem_clk_stop`, `mc_stop_req` and `gk_stop_req` fall one cycle later. `arb_stop_req` falls one cycle after both memory acks are low. `core_qack_n` rises and `ext_quiesce` falls one cycle after `arb_stop_ack` is low.
- R9: Reset leaves all stop requests low, `mem_clk_stop` low, `iso_en` low, `ext_pwr_ctrl` high, `core_qack_n` high, `ext_quiesce` low, `busy` low, `cur_state` 00 and `evt_pending` low.
- R10: `busy` is high in every sequencer state except run and sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sw_cfg_we | input | 1 | Write strobe for next-state, enables and power-off bit |
| sw_next | input | 2 | Next-state code to write |
| sw_sleep_en | input | 1 | Sleep power-down permission to write |
| sw_nap_en | input | 1 | Nap power-down permission to write |
| sw_pwr_off | input | 1 | Power-off bit to write |
| sw_commit | input | 1 | Copy next state into current state |
| evt_set | input | 1 | Set the pending event flag |
| evt_clr | input | 1 | Request to clear the pending event flag |
| settle_cnt | input | SETTLE_W | Power settle count used on wake |
| core_qreq_n | input | 1 | Core quiesce request, active low |
| core_qack_n | output | 1 | Core quiesce acknowledge, active low |
| arb_stop_req | output | 1 | Stop request to the bus arbiter |
| arb_stop_ack | input | 1 | Bus arbiter stop acknowledge |
| mc_stop_req | output | 1 | Stop request to the memory controller |
| mc_stop_ack | input | 1 | Memory controller stop acknowledge |
| gk_stop_req | output | 1 | Stop request to the bridge gasket |
| gk_stop_ack | input | 1 | Bridge gasket stop acknowledge |
| mem_clk_stop | output | 1 | Memory clock stop |
| iso_en | output | 1 | Isolation cell enable |
| ext_quiesce | output | 1 | External quiesce indication |
| ext_pwr_ctrl | output | 1 | External power switch control, high keeps supply on |
| wake | input | 1 | Wake-up pulse |
| busy | output | 1 | Sequencer is in transit |
| cur_state | output | 2 | Committed current state |
| evt_pending | output | 1 | Pending power-management event flag |

## Verification
The assertions assume the stop acknowledges follow a four-phase handshake. Each acknowledge rises only while its request is high, stays high until the request drops, and then falls. The assertions also assume the core releases its quiesce request when it sends the wake pulse. The bench drives the acknowledges by hand in exactly that order, one at a time, so the cycle in which each output moves can be pinned. It sweeps every next-state code against every combination of the two enables, and varies the settle count and the power-off bit across the runs that enter sleep.

// File: rtl/lp_seq_pkg.sv
package lp_seq_pkg;
  localparam int PM_W = 2;
  localparam logic [PM_W-1:0] PM_RUN   = 2'b00;
  localparam logic [PM_W-1:0] PM_NAP   = 2'b01;
  localparam logic [PM_W-1:0] PM_SLEEP = 2'b10;

  typedef enum logic [3:0] {
    ST_RUN    = 4'd0,
    ST_ARB    = 4'd1,
    ST_MEMGK  = 4'd2,
    ST_ISO    = 4'd3,
    ST_SLEEP  = 4'd4,
    ST_SETTLE = 4'd5,
    ST_UNISO  = 4'd6,
    ST_MEMREL = 4'd7,
    ST_ARBREL = 4'd8
  } seq_st_t;
endpackage

// File: rtl/lp_seq_regs.sv
module lp_seq_regs
  import lp_seq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [PM_W-1:0] cfg_next,
  input  logic            cfg_sleep_en,
  input  logic            cfg_nap_en,
  input  logic            cfg_pwr_off,
  input  logic            commit,
  input  logic            evt_set,
  input  logic            evt_clr,
  output logic [PM_W-1:0] cur_state,
  output logic            pwr_off,
  output logic            evt_pending,
  output logic            permit
);
  logic [PM_W-1:0] next_q, next_d, cur_d;
  logic            slp_q, nap_q, slp_d, nap_d, poff_d, evt_d;

  always_comb begin
    next_d = next_q;
    slp_d  = slp_q;
    nap_d  = nap_q;
    poff_d = pwr_off;
    if (cfg_we) begin
      next_d = cfg_next;
      slp_d  = cfg_sleep_en;
      nap_d  = cfg_nap_en;
      poff_d = cfg_pwr_off;
    end
    cur_d = commit ? next_q : cur_state;
    evt_d = evt_pending;
    if (evt_clr && (cur_state == next_q)) evt_d = 1'b0;
    if (evt_set) evt_d = 1'b1;
  end

  assign permit = ((next_q == PM_SLEEP) && slp_q) || ((next_q == PM_NAP) && nap_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      next_q      <= PM_RUN;
      cur_state   <= PM_RUN;
      slp_q       <= 1'b0;
      nap_q       <= 1'b0;
      pwr_off     <= 1'b0;
      evt_pending <= 1'b0;
    end else begin
      next_q      <= next_d;
      cur_state   <= cur_d;
      slp_q       <= slp_d;
      nap_q       <= nap_d;
      pwr_off     <= poff_d;
      evt_pending <= evt_d;
    end
  end
endmodule

// File: rtl/lp_settle_timer.sv
module lp_settle_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         run,
  output logic         done
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) cnt_d = load_val;
    else if (run && (cnt_q != '0)) cnt_d = cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/lp_seq_fsm.sv
module lp_seq_fsm
  import lp_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic permit,
  input  logic pwr_off,
  input  logic core_qreq_n,
  input  logic arb_stop_ack,
  input  logic mc_stop_ack,
  input  logic gk_stop_ack,
  input  logic wake,
  input  logic tmr_done,
  output logic tmr_load,
  output logic tmr_run,
  output logic core_qack_n,
  output logic arb_stop_req,
  output logic mc_stop_req,
  output logic gk_stop_req,
  output logic mem_clk_stop,
  output logic iso_en,
  output logic ext_quiesce,
  output logic ext_pwr_ctrl,
  output logic busy
);
  seq_st_t st_q, st_d;
  logic    clk_stop_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_RUN:    if (!core_qreq_n && permit)     st_d = ST_ARB;
      ST_ARB:    if (arb_stop_ack)               st_d = ST_MEMGK;
      ST_MEMGK:  if (mc_stop_ack && gk_stop_ack) st_d = ST_ISO;
      ST_ISO:                                    st_d = ST_SLEEP;
      ST_SLEEP:  if (wake)                       st_d = ST_SETTLE;
      ST_SETTLE: if (tmr_done)                   st_d = ST_UNISO;
      ST_UNISO:                                  st_d = ST_MEMREL;
      ST_MEMREL: if (!mc_stop_ack && !gk_stop_ack) st_d = ST_ARBREL;
      ST_ARBREL: if (!arb_stop_ack)              st_d = ST_RUN;
      default:                                   st_d = ST_RUN;
    endcase
  end

  always_comb begin
    clk_stop_d = mem_clk_stop;
    if (st_q == ST_MEMGK && mc_stop_ack) clk_stop_d = 1'b1;
    else if (st_q == ST_UNISO)           clk_stop_d = 1'b0;
  end

  assign tmr_load = (st_q == ST_SLEEP) && wake;
  assign tmr_run  = (st_q == ST_SETTLE);

  always_comb begin
    arb_stop_req = 1'b0;
    mc_stop_req  = 1'b0;
    iso_en       = 1'b0;
    core_qack_n  = 1'b1;
    ext_pwr_ctrl = 1'b1;
    busy         = 1'b1;
    unique case (st_q)
      ST_RUN:    busy = 1'b0;
      ST_ARB:    arb_stop_req = 1'b1;
      ST_MEMGK:  begin arb_stop_req = 1'b1; mc_stop_req = 1'b1; end
      ST_ISO:    begin arb_stop_req = 1'b1; mc_stop_req = 1'b1; iso_en = 1'b1; end
      ST_SLEEP:  begin
                   arb_stop_req = 1'b1; mc_stop_req = 1'b1; iso_en = 1'b1;
                   core_qack_n = 1'b0; ext_pwr_ctrl = !pwr_off; busy = 1'b0;
                 end
      ST_SETTLE: begin
                   arb_stop_req = 1'b1; mc_stop_req = 1'b1; iso_en = 1'b1;
                   core_qack_n = 1'b0;
                 end
      ST_UNISO:  begin arb_stop_req = 1'b1; mc_stop_req = 1'b1; core_qack_n = 1'b0; end
      ST_MEMREL: begin arb_stop_req = 1'b1; core_qack_n = 1'b0; end
      ST_ARBREL: core_qack_n = 1'b0;
      default:   busy = 1'b1;
    endcase
    gk_stop_req = mc_stop_req;
    ext_quiesce = !core_qack_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q         <= ST_RUN;
      mem_clk_stop <= 1'b0;
    end else begin
      st_q         <= st_d;
      mem_clk_stop <= clk_stop_d;
    end
  end
endmodule

// File: rtl/lp_quiesce_seq.sv
module lp_quiesce_seq
  import lp_seq_pkg::*;
#(
  parameter int SETTLE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sw_cfg_we,
  input  logic [1:0]          sw_next,
  input  logic                sw_sleep_en,
  input  logic                sw_nap_en,
  input  logic                sw_pwr_off,
  input  logic                sw_commit,
  input  logic                evt_set,
  input  logic                evt_clr,
  input  logic [SETTLE_W-1:0] settle_cnt,
  input  logic                core_qreq_n,
  output logic                core_qack_n,
  output logic                arb_stop_req,
  input  logic                arb_stop_ack,
  output logic                mc_stop_req,
  input  logic                mc_stop_ack,
  output logic                gk_stop_req,
  input  logic                gk_stop_ack,
  output logic                mem_clk_stop,
  output logic                iso_en,
  output logic                ext_quiesce,
  output logic                ext_pwr_ctrl,
  input  logic                wake,
  output logic                busy,
  output logic [1:0]          cur_state,
  output logic                evt_pending
);
  logic permit, pwr_off, tmr_load, tmr_run, tmr_done;

  lp_seq_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(sw_cfg_we), .cfg_next(sw_next),
    .cfg_sleep_en(sw_sleep_en), .cfg_nap_en(sw_nap_en), .cfg_pwr_off(sw_pwr_off),
    .commit(sw_commit), .evt_set(evt_set), .evt_clr(evt_clr),
    .cur_state(cur_state), .pwr_off(pwr_off), .evt_pending(evt_pending),
    .permit(permit)
  );

  lp_settle_timer #(.W(SETTLE_W)) u_timer (
    .clk(clk), .rst_n(rst_n),
    .load(tmr_load), .load_val(settle_cnt), .run(tmr_run), .done(tmr_done)
  );

  lp_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n),
    .permit(permit), .pwr_off(pwr_off), .core_qreq_n(core_qreq_n),
    .arb_stop_ack(arb_stop_ack), .mc_stop_ack(mc_stop_ack), .gk_stop_ack(gk_stop_ack),
    .wake(wake), .tmr_done(tmr_done),
    .tmr_load(tmr_load), .tmr_run(tmr_run),
    .core_qack_n(core_qack_n), .arb_stop_req(arb_stop_req),
    .mc_stop_req(mc_stop_req), .gk_stop_req(gk_stop_req),
    .mem_clk_stop(mem_clk_stop), .iso_en(iso_en),
    .ext_quiesce(ext_quiesce), .ext_pwr_ctrl(ext_pwr_ctrl), .busy(busy)
  );
endmodule

// File: rtl/lp_quiesce_seq_chk.sv
module lp_quiesce_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic core_qack_n,
  input logic arb_stop_req,
  input logic arb_stop_ack,
  input logic mc_stop_req,
  input logic mc_stop_ack,
  input logic gk_stop_req,
  input logic mem_clk_stop,
  input logic iso_en,
  input logic ext_pwr_ctrl
);
  a_r1_mem_stop_after_arb_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mc_stop_req) |-> $past(arb_stop_ack));

  a_r2_arb_held_under_mem: assert property (@(posedge clk) disable iff (!rst_n)
    mc_stop_req |-> arb_stop_req);

  a_r3_clk_stop_after_mc_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_clk_stop) |-> $past(mc_stop_ack) && mc_stop_req);

  a_r4_iso_before_qack: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_qack_n) |-> iso_en && $past(iso_en));

  a_r5_pwr_off_guarded: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_pwr_ctrl |-> iso_en && !core_qack_n);

  a_r8_power_before_uniso: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(iso_en) |-> ext_pwr_ctrl && $past(ext_pwr_ctrl));

  a_r8_arb_release_last: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(arb_stop_req) |-> !mc_stop_req && !gk_stop_req);
endmodule

bind lp_quiesce_seq lp_quiesce_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .core_qack_n(core_qack_n),
  .arb_stop_req(arb_stop_req), .arb_stop_ack(arb_stop_ack),
  .mc_stop_req(mc_stop_req), .mc_stop_ack(mc_stop_ack),
  .gk_stop_req(gk_stop_req), .mem_clk_stop(mem_clk_stop),
  .iso_en(iso_en), .ext_pwr_ctrl(ext_pwr_ctrl)
);

// File: tb/lp_quiesce_seq_bench.sv
module lp_quiesce_seq_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       sw_cfg_we, sw_sleep_en, sw_nap_en, sw_pwr_off, sw_commit;
  logic [1:0] sw_next;
  logic       evt_set, evt_clr, core_qreq_n, wake;
  logic       arb_stop_ack, mc_stop_ack, gk_stop_ack;
  logic [7:0] settle_cnt;
  logic       core_qack_n, arb_stop_req, mc_stop_req, gk_stop_req;
  logic       mem_clk_stop, iso_en, ext_quiesce, ext_pwr_ctrl, busy, evt_pending;
  logic [1:0] cur_state;
  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  lp_quiesce_seq u_lp_quiesce_seq (
    .clk(clk), .rst_n(rst_n), .sw_cfg_we(sw_cfg_we), .sw_next(sw_next),
    .sw_sleep_en(sw_sleep_en), .sw_nap_en(sw_nap_en), .sw_pwr_off(sw_pwr_off),
    .sw_commit(sw_commit), .evt_set(evt_set), .evt_clr(evt_clr),
    .settle_cnt(settle_cnt), .core_qreq_n(core_qreq_n), .core_qack_n(core_qack_n),
    .arb_stop_req(arb_stop_req), .arb_stop_ack(arb_stop_ack),
    .mc_stop_req(mc_stop_req), .mc_stop_ack(mc_stop_ack),
    .gk_stop_req(gk_stop_req), .gk_stop_ack(gk_stop_ack),
    .mem_clk_stop(mem_clk_stop), .iso_en(iso_en), .ext_quiesce(ext_quiesce),
    .ext_pwr_ctrl(ext_pwr_ctrl), .wake(wake), .busy(busy),
    .cur_state(cur_state), .evt_pending(evt_pending)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic run_seq(input int n, input bit poff);
    chk("R1", "mc held", mc_stop_req, 0);
    chk("R1", "gk held", gk_stop_req, 0);
    chk("R10", "busy arb", busy, 1);
    arb_stop_ack = 1'b1; step();
    chk("R2", "mc req", mc_stop_req, 1);
    chk("R2", "gk req", gk_stop_req, 1);
    chk("R3", "clk before ack", mem_clk_stop, 0);
    mc_stop_ack = 1'b1; step();
    chk("R3", "clk stop", mem_clk_stop, 1);
    chk("R4", "iso early", iso_en, 0);
    gk_stop_ack = 1'b1; step();
    chk("R4", "iso on", iso_en, 1);
    chk("R4", "qack early", core_qack_n, 1);
    step();
    chk("R4", "qack", core_qack_n, 0);
    chk("R4", "ext quiesce", ext_quiesce, 1);
    chk("R5", "pwr ctrl", ext_pwr_ctrl, poff ? 0 : 1);
    chk("R10", "busy sleep", busy, 0);
    step();
    chk("R5", "pwr ctrl held", ext_pwr_ctrl, poff ? 0 : 1);
    wake = 1'b1; core_qreq_n = 1'b1; step(); wake = 1'b0;
    chk("R8", "pwr restored", ext_pwr_ctrl, 1);
    chk("R10", "busy settle", busy, 1);
    begin
      int cnt = 0;
      while (iso_en && cnt < 300) begin cnt++; step(); end
      chk("R8", "settle cycles", cnt, n + 1);
    end
    chk("R8", "clk still stopped", mem_clk_stop, 1);
    step();
    chk("R8", "clk restart", mem_clk_stop, 0);
    chk("R8", "mc released", mc_stop_req, 0);
    chk("R8", "gk released", gk_stop_req, 0);
    chk("R8", "arb still held", arb_stop_req, 1);
    mc_stop_ack = 1'b0; gk_stop_ack = 1'b0; step();
    chk("R8", "arb released", arb_stop_req, 0);
    chk("R8", "qack held", core_qack_n, 0);
    arb_stop_ack = 1'b0; step();
    chk("R8", "qack released", core_qack_n, 1);
    chk("R8", "quiesce released", ext_quiesce, 0);
    chk("R10", "busy run", busy, 0);
  endtask

  initial begin
    rst_n = 1'b0;
    sw_cfg_we = 0; sw_next = 0; sw_sleep_en = 0; sw_nap_en = 0; sw_pwr_off = 0;
    sw_commit = 0; evt_set = 0; evt_clr = 0; core_qreq_n = 1; wake = 0;
    arb_stop_ack = 0; mc_stop_ack = 0; gk_stop_ack = 0; settle_cnt = 0;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    chk("R9", "arb", arb_stop_req, 0);
    chk("R9", "mc", mc_stop_req, 0);
    chk("R9", "gk", gk_stop_req, 0);
    chk("R9", "clk", mem_clk_stop, 0);
    chk("R9", "iso", iso_en, 0);
    chk("R9", "pwr", ext_pwr_ctrl, 1);
    chk("R9", "qack", core_qack_n, 1);
    chk("R9", "quiesce", ext_quiesce, 0);
    chk("R9", "busy", busy, 0);
    chk("R9", "cur", cur_state, 0);
    chk("R9", "evt", evt_pending, 0);

    for (int code = 0; code < 4; code++) begin
      for (int en = 0; en < 4; en++) begin
        bit go;
        bit poff;
        int n;
        go   = (code == 2 && en[1]) || (code == 1 && en[0]);
        poff = ((code + en) % 2) == 1;
        n    = (code * 4 + en) % 6;
        sw_cfg_we = 1; sw_next = code[1:0]; sw_sleep_en = en[1]; sw_nap_en = en[0];
        sw_pwr_off = poff; settle_cnt = n[7:0];
        step(); sw_cfg_we = 0;
        core_qreq_n = 1'b0;
        repeat (3) step();
        chk("R7", "start", arb_stop_req, go ? 1 : 0);
        if (go) run_seq(n, poff);
        else begin
          chk("R7", "qack idle", core_qack_n, 1);
          chk("R7", "mc idle", mc_stop_req, 0);
          core_qreq_n = 1'b1; step();
        end
      end
    end

    evt_set = 1; step(); evt_set = 0;
    chk("R6", "evt set", evt_pending, 1);
    sw_cfg_we = 1; sw_next = 2'b01; step(); sw_cfg_we = 0;
    evt_clr = 1; step(); evt_clr = 0;
    chk("R6", "clear ignored", evt_pending, 1);
    chk("R6", "cur unchanged", cur_state, 0);
    sw_commit = 1; step(); sw_commit = 0;
    chk("R6", "commit", cur_state, 1);
    evt_clr = 1; step(); evt_clr = 0;
    chk("R6", "clear done", evt_pending, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule